// File: doc/BRIEF.md
# Protection Unit Status, Interrupt and Flush Controller

This block is the register-side control for an I/O memory protection unit. It keeps a six-bit status register of error and event flags, an interrupt mask register, and a flush command register that starts an invalidation walk over a protection-vector cache. The walk can cover every line or only the lines of one group. The start and the end of each flush are recorded as status events. A single level interrupt line is raised while any unmasked status flag is set.

The block also holds the unit's enable bit. A write sets a requested mode. The effective mode follows it only after a fixed switching latency, and the enable bit reads back the effective mode. Software can therefore poll the bit until the change has taken effect. The cache storage and the bus slave decoding sit outside this block. Software reaches the registers through a plain write strobe, a word address and a registered read-data bus. The cache is driven through a line-index strobe.

Top module: `prot_ctl_unit`

## Requirements
- R1: After reset, all status flags, all mask bits, the enable readback, `irq` and `inv_valid` are 0.
- R2: A pulse on an event input sets its status flag on the next clock edge. Status bit positions: 0 translation error, 1 access denied, 2 flush started, 3 flush completed, 4 decode error, 5 parity error. The status register is at word address 2.
- R3: Writing the status register clears each flag whose written data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R4: The mask register, at word address 3, stores data bits 0, 1, 2, 3 and 5. Bit 4 always reads 0.
- R5: `irq` is 1 exactly when some status flag and its mask bit are both 1. It changes on the same edge as the status and mask registers.
- R6: A write to the flush register (word address 1) with data bit 0 set, while no flush is running, is accepted on that edge. On that edge the flush-started flag is set and `inv_valid` rises with `inv_line` = 0.
- R7: An accepted flush presents each line index 0 to LINES-1 in ascending order, one per cycle. On the edge after the last index, `inv_valid` falls and the flush-completed flag is set.
- R8: Data bit 1 of the flush command selects a group-only flush, and data bits 7:4 give the group number. Both are held on `inv_group_only` and `inv_group` for the whole walk.
- R9: A flush command written while a walk is running is ignored: the walk is neither restarted nor lengthened, and its group outputs do not change.
- R10: If an event and a software clear hit the same status flag on the same edge, the flag ends up set.
- R11: Writing data bit 0 of the control register (word address 0) sets the requested mode. `unit_enabled` and the readback of control bit 0 take the requested value MODE_LAT edges after the write edge.
- R12: Reading the flush register returns bit 0 = walk in progress, bit 1 = group-only flag and bits 7:4 = group of the current or last walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address of the register accessed |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data for the address of the previous cycle |
| ev_xlate_err | input | 1 | Translation error event pulse |
| ev_access_deny | input | 1 | Access denied event pulse |
| ev_decode_err | input | 1 | Decode error event pulse |
| ev_parity_err | input | 1 | Parity error event pulse |
| unit_enabled | output | 1 | Effective protection mode |
| irq | output | 1 | Interrupt request, level |
| inv_valid | output | 1 | Invalidation walk strobe for the cache |
| inv_line | output | LINE_W | Cache line to invalidate this cycle |
| inv_group_only | output | 1 | Walk targets only the lines of inv_group |
| inv_group | output | GROUP_W | Target group of the walk |

## Verification
The assertions assume that event inputs are single-cycle pulses sampled on the clock edge. They also assume that register writes use only the four defined word addresses, and that no write lands on the reset cycle. The bench drives every input at the falling edge and holds each write for exactly one cycle. It raises events only while no status write to the same flag is pending, except in the deliberate collision case for R10. The bench sweeps all 64 mask patterns against a fixed event pattern. It walks complete flushes of the default sixteen-line configuration, including one with a second command issued in the middle of the walk.

// File: rtl/pu_ctl_pkg.sv
package pu_ctl_pkg;

  // Status flag positions; software and the interrupt mask rely on them.
  localparam int STAT_W    = 6;
  localparam int ST_XLATE  = 0;
  localparam int ST_DENY   = 1;
  localparam int ST_FSTART = 2;
  localparam int ST_FDONE  = 3;
  localparam int ST_DECODE = 4;
  localparam int ST_PARITY = 5;

  // Mask bits that have storage behind them (no mask for decode error).
  localparam logic [STAT_W-1:0] MASK_IMPL = 6'b10_1111;

  // Flush command field positions.
  localparam int FL_GO    = 0;
  localparam int FL_GONLY = 1;
  localparam int FL_GRP   = 4;

  typedef enum logic [1:0] {
    RSEL_CTRL  = 2'd0,
    RSEL_FLUSH = 2'd1,
    RSEL_STAT  = 2'd2,
    RSEL_MASK  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/pu_mode_switch.sv
module pu_mode_switch #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  logic val_i,
  output logic req_o,
  output logic eff_o
);
  localparam int CNT_W = (LAT > 1) ? $clog2(LAT + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAT - 1);

  logic             req_q;
  logic             eff_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      eff_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (wr_i) req_q <= val_i;
      if (req_q != eff_q) begin
        if (cnt_q == CNT_LAST) begin
          eff_q <= req_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign req_o = req_q;
  assign eff_o = eff_q;
endmodule

// File: rtl/pu_flush_walk.sv
module pu_flush_walk #(
  parameter int LINES   = 16,
  parameter int GROUP_W = 4,
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go_i,
  input  logic               gonly_i,
  input  logic [GROUP_W-1:0] grp_i,
  output logic               start_o,
  output logic               done_o,
  output logic               busy_o,
  output logic [LINE_W-1:0]  line_o,
  output logic               gonly_o,
  output logic [GROUP_W-1:0] grp_o
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(LINES - 1);

  logic               busy_q;
  logic [LINE_W-1:0]  line_q;
  logic               gonly_q;
  logic [GROUP_W-1:0] grp_q;

  // A command is only taken when idle; one arriving mid-walk is dropped.
  assign start_o = go_i && !busy_q;
  assign done_o  = busy_q && (line_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      line_q  <= '0;
      gonly_q <= 1'b0;
      grp_q   <= '0;
    end else if (start_o) begin
      busy_q  <= 1'b1;
      line_q  <= '0;
      gonly_q <= gonly_i;
      grp_q   <= grp_i;
    end else if (busy_q) begin
      if (line_q == LAST) begin
        busy_q <= 1'b0;
        line_q <= '0;
      end else begin
        line_q <= line_q + 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign line_o  = line_q;
  assign gonly_o = gonly_q;
  assign grp_o   = grp_q;
endmodule

// File: rtl/pu_status_irq.sv
module pu_status_irq
  import pu_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  input  logic              mask_we_i,
  input  logic [STAT_W-1:0] mask_wdata_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] mask_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] stat_q, stat_d;
  logic [STAT_W-1:0] mask_q, mask_d;
  logic              irq_q;

  // Set terms are applied after the clear so a coinciding event survives.
  always_comb begin
    stat_d = (stat_q & ~clr_i) | set_i;
    mask_d = mask_we_i ? (mask_wdata_i & MASK_IMPL) : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq_q  <= |(stat_d & mask_d);
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/prot_ctl_unit.sv
module prot_ctl_unit
  import pu_ctl_pkg::*;
#(
  parameter int LINES    = 16,
  parameter int GROUP_W  = 4,
  parameter int MODE_LAT = 3,
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 32,
  localparam int LINE_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               ev_xlate_err,
  input  logic               ev_access_deny,
  input  logic               ev_decode_err,
  input  logic               ev_parity_err,
  output logic               unit_enabled,
  output logic               irq,
  output logic               inv_valid,
  output logic [LINE_W-1:0]  inv_line,
  output logic               inv_group_only,
  output logic [GROUP_W-1:0] inv_group
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr[1:0]);

  logic wr_ctrl, wr_flush, wr_stat, wr_mask;
  assign wr_ctrl  = wr_en && (sel == RSEL_CTRL);
  assign wr_flush = wr_en && (sel == RSEL_FLUSH);
  assign wr_stat  = wr_en && (sel == RSEL_STAT);
  assign wr_mask  = wr_en && (sel == RSEL_MASK);

  // Enable request and delayed effective mode
  logic mode_req, mode_eff;
  pu_mode_switch #(.LAT(MODE_LAT)) u_mode (
    .clk  (clk),
    .rst  (rst),
    .wr_i (wr_ctrl),
    .val_i(wdata[0]),
    .req_o(mode_req),
    .eff_o(mode_eff)
  );

  // Invalidation walk
  logic fl_start, fl_done, fl_busy, fl_gonly;
  logic [LINE_W-1:0]  fl_line;
  logic [GROUP_W-1:0] fl_grp;
  pu_flush_walk #(.LINES(LINES), .GROUP_W(GROUP_W)) u_walk (
    .clk    (clk),
    .rst    (rst),
    .go_i   (wr_flush && wdata[FL_GO]),
    .gonly_i(wdata[FL_GONLY]),
    .grp_i  (wdata[FL_GRP +: GROUP_W]),
    .start_o(fl_start),
    .done_o (fl_done),
    .busy_o (fl_busy),
    .line_o (fl_line),
    .gonly_o(fl_gonly),
    .grp_o  (fl_grp)
  );

  // Status, mask, interrupt
  logic [STAT_W-1:0] stat_set, stat_clr, stat_q, mask_q;
  always_comb begin
    stat_set            = '0;
    stat_set[ST_XLATE]  = ev_xlate_err;
    stat_set[ST_DENY]   = ev_access_deny;
    stat_set[ST_FSTART] = fl_start;
    stat_set[ST_FDONE]  = fl_done;
    stat_set[ST_DECODE] = ev_decode_err;
    stat_set[ST_PARITY] = ev_parity_err;
    stat_clr            = wr_stat ? wdata[STAT_W-1:0] : '0;
  end

  pu_status_irq u_stat (
    .clk         (clk),
    .rst         (rst),
    .set_i       (stat_set),
    .clr_i       (stat_clr),
    .mask_we_i   (wr_mask),
    .mask_wdata_i(wdata[STAT_W-1:0]),
    .stat_o      (stat_q),
    .mask_o      (mask_q),
    .irq_o       (irq)
  );

  // Registered read-back
  logic [DATA_W-1:0] rd_d, rd_q;
  always_comb begin
    rd_d = '0;
    unique case (sel)
      RSEL_CTRL:  rd_d[0] = mode_eff;
      RSEL_FLUSH: begin
        rd_d[0]                 = fl_busy;
        rd_d[FL_GONLY]          = fl_gonly;
        rd_d[FL_GRP +: GROUP_W] = fl_grp;
      end
      RSEL_STAT:  rd_d[STAT_W-1:0] = stat_q;
      RSEL_MASK:  rd_d[STAT_W-1:0] = mask_q;
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  assign rdata          = rd_q;
  assign unit_enabled   = mode_eff;
  assign inv_valid      = fl_busy;
  assign inv_line       = fl_line;
  assign inv_group_only = fl_gonly;
  assign inv_group      = fl_grp;
endmodule

// File: rtl/pu_ctl_checker.sv
module pu_ctl_checker #(
  parameter int LINES   = 16,
  parameter int GROUP_W = 4,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 32,
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic               ev_xlate_err,
  input logic               ev_access_deny,
  input logic               ev_parity_err,
  input logic               unit_enabled,
  input logic               irq,
  input logic               inv_valid,
  input logic [LINE_W-1:0]  inv_line,
  input logic               inv_group_only,
  input logic [GROUP_W-1:0] inv_group,
  input logic [5:0]         status,
  input logic [5:0]         mask,
  input logic               mode_req
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(LINES - 1);

  p_event_sets_r2: assert property (@(posedge clk) disable iff (rst)
    ev_xlate_err |=> status[0]);

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(2) && wdata[1] && !ev_access_deny) |=> !status[1]);

  p_irq_follow_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_parity_err && mask[5] && !(wr_en && addr == ADDR_W'(3))) |=> irq);

  p_flush_start_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(1) && wdata[0] && !inv_valid)
      |=> (status[2] && inv_valid && inv_line == '0));

  p_flush_done_r7: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_line == LAST) |=> (status[3] && !inv_valid));

  p_walk_step_r9: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_line != LAST)
      |=> (inv_valid && inv_line == $past(inv_line) + 1'b1
           && $stable(inv_group) && $stable(inv_group_only)));

  p_enable_rise_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(unit_enabled) |-> mode_req);

  p_enable_fall_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(unit_enabled) |-> !mode_req);
endmodule

bind prot_ctl_unit pu_ctl_checker #(
  .LINES(LINES), .GROUP_W(GROUP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .addr          (addr),
  .wdata         (wdata),
  .ev_xlate_err  (ev_xlate_err),
  .ev_access_deny(ev_access_deny),
  .ev_parity_err (ev_parity_err),
  .unit_enabled  (unit_enabled),
  .irq           (irq),
  .inv_valid     (inv_valid),
  .inv_line      (inv_line),
  .inv_group_only(inv_group_only),
  .inv_group     (inv_group),
  .status        (stat_q),
  .mask          (mask_q),
  .mode_req      (mode_req)
);

// File: tb/prot_ctl_unit_test.sv
`timescale 1ns/1ps
module prot_ctl_unit_test;
  localparam int LINES    = 16;
  localparam int GROUP_W  = 4;
  localparam int MODE_LAT = 3;
  localparam int LINE_W   = $clog2(LINES);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic ev_x = 1'b0, ev_d = 1'b0, ev_dec = 1'b0, ev_p = 1'b0;
  logic unit_enabled, irq, inv_valid, inv_group_only;
  logic [LINE_W-1:0]  inv_line;
  logic [GROUP_W-1:0] inv_group;

  always #2.5 clk = ~clk;

  prot_ctl_unit #(.LINES(LINES), .GROUP_W(GROUP_W), .MODE_LAT(MODE_LAT)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ev_xlate_err(ev_x), .ev_access_deny(ev_d), .ev_decode_err(ev_dec),
    .ev_parity_err(ev_p), .unit_enabled(unit_enabled), .irq(irq),
    .inv_valid(inv_valid), .inv_line(inv_line), .inv_group_only(inv_group_only),
    .inv_group(inv_group)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic pulse(input logic [3:0] ev);
    {ev_p, ev_dec, ev_d, ev_x} = ev;
    @(negedge clk);
    {ev_p, ev_dec, ev_d, ev_x} = 4'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [5:0]  exp_m;
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    chk(inv_valid == 1'b0, "R1 inv_valid", 32'(inv_valid), 0);
    chk(unit_enabled == 1'b0, "R1 enable", 32'(unit_enabled), 0);
    rd(2'd2, v); chk(v == 0, "R1 status", v, 0);
    rd(2'd3, v); chk(v == 0, "R1 mask", v, 0);
    rd(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);

    // R2 each event sets its own flag
    pulse(4'b0001); rd(2'd2, v); chk(v == 32'h01, "R2 xlate", v, 32'h01);
    pulse(4'b0010); rd(2'd2, v); chk(v == 32'h03, "R2 deny", v, 32'h03);
    pulse(4'b0100); rd(2'd2, v); chk(v == 32'h13, "R2 decode", v, 32'h13);
    pulse(4'b1000); rd(2'd2, v); chk(v == 32'h33, "R2 parity", v, 32'h33);

    // R3 selective write-one-to-clear
    wr(2'd2, 32'h02); rd(2'd2, v); chk(v == 32'h31, "R3 clear bit1", v, 32'h31);
    wr(2'd2, 32'h30); rd(2'd2, v); chk(v == 32'h01, "R3 clear bits5:4", v, 32'h01);

    // R10 event and clear collide on bit 0: event wins
    ev_x = 1'b1; wr(2'd2, 32'h01); ev_x = 1'b0;
    rd(2'd2, v); chk(v == 32'h01, "R10 event wins", v, 32'h01);
    wr(2'd2, 32'h01); rd(2'd2, v); chk(v == 32'h00, "R3 plain clear", v, 32'h00);

    // R4/R5 sweep all mask patterns against event pattern 6'h33
    for (int m = 0; m < 64; m++) begin
      exp_m = 6'(m) & 6'h2F;
      wr(2'd3, 32'(m));
      rd(2'd3, v); chk(v == 32'(exp_m), "R4 mask readback", v, 32'(exp_m));
      wr(2'd2, 32'h3F);
      chk(irq == 1'b0, "R5 irq after clear", 32'(irq), 0);
      pulse(4'b1111);
      chk(irq == |(exp_m & 6'h33), "R5 irq sweep", 32'(irq), 32'(|(exp_m & 6'h33)));
    end

    // R6/R7/R8 group-only flush, only flush-started unmasked
    wr(2'd2, 32'h3F);
    wr(2'd3, 32'h04);
    wr(2'd1, 32'h53);            // go, group-only, group 5
    for (int i = 0; i < LINES; i++) begin
      if (i == 0) begin
        chk(irq == 1'b1, "R5 flush start irq", 32'(irq), 1);
        addr = 2'd2;
      end
      if (i == 1) chk(rdata[5:0] == 6'h04, "R6 start flag", rdata, 32'h04);
      chk(inv_valid == 1'b1, "R7 valid in walk", 32'(inv_valid), 1);
      chk(inv_line == LINE_W'(i), "R7 line order", 32'(inv_line), 32'(i));
      chk(inv_group_only && inv_group == 4'd5, "R8 group fields",
          {inv_group_only, 4'b0, inv_group}, 32'h105);
      @(negedge clk);
    end
    chk(inv_valid == 1'b0, "R7 walk ends", 32'(inv_valid), 0);
    rd(2'd2, v); chk(v == 32'h0C, "R7 done flag", v, 32'h0C);
    rd(2'd1, v); chk(v == 32'h52, "R12 idle readback", v, 32'h52);

    // R9/R12 full flush of group 2 with a second command mid-walk
    wr(2'd2, 32'h3F);
    wr(2'd1, 32'h21);
    cnt = 0;
    for (int i = 0; i < LINES + 4; i++) begin
      if (inv_valid) cnt++;
      if (i == 3) begin wr_en = 1'b1; addr = 2'd1; wdata = 32'h93; end
      if (i == 4) begin wr_en = 1'b0; wdata = '0; addr = 2'd1; end
      if (i == 6) chk(rdata == 32'h21, "R12 busy readback", rdata, 32'h21);
      if (inv_valid)
        chk(!inv_group_only && inv_group == 4'd2, "R9 group held",
            {inv_group_only, 4'b0, inv_group}, 32'h002);
      @(negedge clk);
    end
    chk(cnt == LINES, "R9 walk length", 32'(cnt), 32'(LINES));
    rd(2'd2, v); chk(v == 32'h0C, "R9 single start/done", v, 32'h0C);

    // R11 enable readback lags by MODE_LAT edges
    wr(2'd0, 32'h1);
    addr = 2'd0;
    for (int j = 0; j <= MODE_LAT + 1; j++) begin
      chk(unit_enabled == (j >= MODE_LAT), "R11 enable lag",
          32'(unit_enabled), 32'(j >= MODE_LAT));
      if (j >= 1)
        chk(rdata[0] == (j - 1 >= MODE_LAT), "R11 ctrl readback",
            rdata, 32'(j - 1 >= MODE_LAT));
      @(negedge clk);
    end
    wr(2'd0, 32'h0);
    for (int j = 0; j <= MODE_LAT; j++) begin
      chk(unit_enabled == (j < MODE_LAT), "R11 disable lag",
          32'(unit_enabled), 32'(j < MODE_LAT));
      @(negedge clk);
    end
    rd(2'd0, v); chk(v == 0, "R11 disabled readback", v, 0);

    finish_run();
  end
endmodule